// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. Configuration software writes a single 32-bit word with byte enables. The low half is slot control and the high half is slot status. The read port always returns both registers.

Hardware events enter on single-cycle strobes: an attention-button press and a device insertion. A slot-populated level is sampled during reset to choose the power defaults. The block latches events into write-one-to-clear status bits. It treats each control write as one command that completes at once. The interlock toggle is handled as a write-only command. When the power-off conditions are met, the block requests detach of the downstream device.

Interrupts are derived from one combined pending condition. When message interrupts are enabled, a change of that condition produces a one-cycle message pulse. When they are disabled, the change drives a level interrupt instead.

Top module: `slot_hp_ctrl`

Register layout, read on `cfg_rd_data` and written through `cfg_wr_data`:

- Slot control, bits 15:0:
  - bit 0: button enable
  - bit 1: presence-changed enable
  - bit 2: command-done enable
  - bit 3: interrupt enable
  - bits 5:4: attention indicator
  - bits 7:6: power indicator
  - bit 8: power off
  - bit 9: lock toggle
- Slot status, bits 31:16:
  - bit 16: button pressed
  - bit 17: presence changed
  - bit 18: command done
  - bit 19: presence state
  - bit 20: lock engaged
- Indicator codes: 01 on, 10 blink, 11 off.

## Requirements
- R1: While `rst_n` is low the registers take their defaults. All enables clear, the lock toggle and lock status clear, and all three event bits clear. The attention indicator reads 11. Presence state equals `slot_populated`. With power control present, power off equals NOT `slot_populated` and the power indicator is 01 when populated and 11 otherwise.
- R2: The pending condition is interrupt enable AND (status bits 2:0 AND control bits 2:0 AND the supported mask) being nonzero. With `msg_enable` high, `msg_pulse` is high for exactly the one cycle after the pending condition changes value, and never otherwise.
- R3: With `msg_enable` low, `irq_level` follows the pending condition on each change. It is 0 whenever the pending condition is false.
- R4: Raising an event bit that is already set produces no pulse and no level change.
- R5: A write with byte 2 enabled clears every status event bit (2:0) written with 1 and leaves the others. A write without byte 2 enabled clears none.
- R6: Writing 1 to bit 9 with byte 1 enabled toggles lock status (bit 20). Bit 9 always reads 0.
- R7: Detach occurs on a control write when three conditions hold: presence state was 1, the resulting power off bit is 1, and the resulting power indicator is 11. Then `detach_req` pulses for one cycle, presence state clears and presence changed sets. Otherwise no detach occurs.
- R8: Any write with byte 0 or byte 1 enabled sets command done (bit 18), after any status clearing in the same write.
- R9: `evt_button` sets bit 16. `evt_insert` sets presence state, presence changed and button pressed.
- R10: `evt_insert` while lock status is 1 changes no status bit and pulses `insert_busy` for one cycle.
- R11: Control fields change only in enabled bytes: byte 0 holds bits 7:0 and byte 1 holds bits 9:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe |
| cfg_wr_be | input | 4 | Byte enables: 1:0 control, 3:2 status |
| cfg_wr_data | input | 32 | Write word |
| cfg_rd_data | output | 32 | Status in 31:16, control in 15:0 |
| evt_button | input | 1 | Attention-button strobe |
| evt_insert | input | 1 | Insertion strobe |
| slot_populated | input | 1 | Slot occupancy, sampled in reset |
| msg_enable | input | 1 | Message interrupts enabled |
| irq_level | output | 1 | Level interrupt |
| msg_pulse | output | 1 | One-cycle message request |
| detach_req | output | 1 | One-cycle detach request |
| insert_busy | output | 1 | One-cycle insertion-rejected flag |
| attn_ind | output | 2 | Attention indicator field |
| pwr_ind | output | 2 | Power indicator field |

## Verification
The assertions assume that event strobes and writes are synchronous to `clk` and free of X after reset. They also assume that `msg_enable` is held steady across the cycle in which the pending condition changes, so that a level rise can be traced to messages being disabled. The bench changes `msg_enable` only between scenarios, while the pending condition is false. It drives every input half a cycle away from the sampling edge.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int REG_W = 16;
    localparam int EVT_N = 3;
    localparam int EN_N  = EVT_N + 1;

    // control bit positions
    localparam int C_INT_EN   = 3;
    localparam int C_ATTN_LO  = 4;
    localparam int C_PWRI_LO  = 6;
    localparam int C_PWR_OFF  = 8;
    localparam int C_LOCK_TGL = 9;

    // status event positions
    localparam int E_BTN  = 0;
    localparam int E_PCHG = 1;
    localparam int E_CMD  = 2;

    localparam logic [1:0] IND_ON    = 2'b01;
    localparam logic [1:0] IND_BLINK = 2'b10;
    localparam logic [1:0] IND_OFF   = 2'b11;

    typedef struct packed {
        logic             pwr_off;
        logic [1:0]       pwr_ind;
        logic [1:0]       attn_ind;
        logic [EN_N-1:0]  en;
    } ctl_t;

    typedef struct packed {
        logic             lock;
        logic             pres;
        logic [EVT_N-1:0] evt;
    } sts_t;

    typedef struct packed {
        ctl_t ctl;
        sts_t sts;
        logic detach;
        logic busy;
    } slot_state_t;
endpackage

// File: rtl/hp_pending_eval.sv
module hp_pending_eval
    import hp_slot_pkg::*;
#(
    parameter logic [EVT_N-1:0] SUPPORTED = '1
) (
    input  logic             int_en,
    input  logic [EVT_N-1:0] evt_sts,
    input  logic [EVT_N-1:0] evt_en,
    output logic             pending
);
    always_comb begin
        pending = int_en && (|(evt_sts & evt_en & SUPPORTED));
    end
endmodule

// File: rtl/hp_notifier.sv
module hp_notifier (
    input  logic clk,
    input  logic rst_n,
    input  logic pending_d,
    input  logic msg_enable,
    output logic irq_level,
    output logic msg_pulse
);
    typedef struct packed {
        logic pend;
        logic irq;
        logic pulse;
    } notif_t;

    notif_t q, d;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (pending_d != q.pend) begin
            d.pend = pending_d;
            if (msg_enable) d.pulse = 1'b1;
            else            d.irq   = pending_d;
        end
        if (!msg_enable && !pending_d) d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_level = q.irq;
    assign msg_pulse = q.pulse;

    // R2: a message pulse follows only a change of the pending condition
    assert_pulse_on_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |-> (q.pend != $past(q.pend)));

    // R3: the level only rises while messages are disabled
    assert_level_no_msg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq) |-> $past(!msg_enable));
endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
    import hp_slot_pkg::*;
#(
    parameter bit               HAS_PWR_CTL   = 1'b1,
    parameter logic [EVT_N-1:0] SUPPORTED_EVT = '1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [3:0]  cfg_wr_be,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic        evt_button,
    input  logic        evt_insert,
    input  logic        slot_populated,
    input  logic        msg_enable,
    output logic        irq_level,
    output logic        msg_pulse,
    output logic        detach_req,
    output logic        insert_busy,
    output logic [1:0]  attn_ind,
    output logic [1:0]  pwr_ind
);
    localparam int STS_LO = REG_W;

    slot_state_t q, d, rst_val;
    logic        pwr_rst_off;
    logic [1:0]  pwr_rst_ind;
    logic        pwr_writable;
    logic        ctl_wr;
    logic        pending_d;
    logic        unused_wdata;

    assign unused_wdata = ^{cfg_wr_data[31:STS_LO+EVT_N], cfg_wr_data[15:10]};

    generate
        if (HAS_PWR_CTL) begin : g_pwr
            assign pwr_rst_ind  = slot_populated ? IND_ON : IND_OFF;
            assign pwr_rst_off  = ~slot_populated;
            assign pwr_writable = 1'b1;
        end else begin : g_nopwr
            assign pwr_rst_ind  = 2'b00;
            assign pwr_rst_off  = 1'b0;
            assign pwr_writable = 1'b0;
        end
    endgenerate

    always_comb begin
        rst_val              = '0;
        rst_val.ctl.attn_ind = IND_OFF;
        rst_val.ctl.pwr_ind  = pwr_rst_ind;
        rst_val.ctl.pwr_off  = pwr_rst_off;
        rst_val.sts.pres     = slot_populated;
    end

    assign ctl_wr = cfg_wr_en && (|cfg_wr_be[1:0]);

    always_comb begin
        d        = q;
        d.detach = 1'b0;
        d.busy   = 1'b0;
        // status write-one-to-clear comes first
        if (cfg_wr_en && cfg_wr_be[2])
            d.sts.evt = d.sts.evt & ~cfg_wr_data[STS_LO +: EVT_N];
        // control field updates per byte
        if (cfg_wr_en && cfg_wr_be[0]) begin
            d.ctl.en       = cfg_wr_data[EN_N-1:0];
            d.ctl.attn_ind = cfg_wr_data[C_ATTN_LO +: 2];
            d.ctl.pwr_ind  = cfg_wr_data[C_PWRI_LO +: 2];
        end
        if (cfg_wr_en && cfg_wr_be[1]) begin
            if (pwr_writable) d.ctl.pwr_off = cfg_wr_data[C_PWR_OFF];
            if (cfg_wr_data[C_LOCK_TGL]) d.sts.lock = ~d.sts.lock;
        end
        // power-off detach rule
        if (ctl_wr && q.sts.pres && d.ctl.pwr_off && (d.ctl.pwr_ind == IND_OFF)) begin
            d.sts.pres         = 1'b0;
            d.sts.evt[E_PCHG]  = 1'b1;
            d.detach           = 1'b1;
        end
        // every control write is a completed command
        if (ctl_wr) d.sts.evt[E_CMD] = 1'b1;
        // hardware events
        if (evt_button) d.sts.evt[E_BTN] = 1'b1;
        if (evt_insert) begin
            if (q.sts.lock) begin
                d.busy = 1'b1;
            end else begin
                d.sts.pres        = 1'b1;
                d.sts.evt[E_PCHG] = 1'b1;
                d.sts.evt[E_BTN]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= rst_val;
        else        q <= d;
    end

    hp_pending_eval #(.SUPPORTED(SUPPORTED_EVT)) u_pend (
        .int_en  (d.ctl.en[C_INT_EN]),
        .evt_sts (d.sts.evt),
        .evt_en  (d.ctl.en[EVT_N-1:0]),
        .pending (pending_d)
    );

    hp_notifier u_notif (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending_d  (pending_d),
        .msg_enable (msg_enable),
        .irq_level  (irq_level),
        .msg_pulse  (msg_pulse)
    );

    assign cfg_rd_data = {{(REG_W-EVT_N-2){1'b0}}, q.sts.lock, q.sts.pres, q.sts.evt,
                          6'b0, 1'b0, q.ctl.pwr_off, q.ctl.pwr_ind, q.ctl.attn_ind, q.ctl.en};
    assign detach_req  = q.detach;
    assign insert_busy = q.busy;
    assign attn_ind    = q.ctl.attn_ind;
    assign pwr_ind     = q.ctl.pwr_ind;

    // R8: a control write always leaves command done set
    assert_cmd_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> q.sts.evt[E_CMD]);

    // R6: a lock-toggle write flips lock status
    assert_lock_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_be[1] && cfg_wr_data[C_LOCK_TGL]) |=> (q.sts.lock != $past(q.sts.lock)));

    // R7: a detach leaves the slot empty with presence changed set
    assert_detach_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.detach |-> (!q.sts.pres && q.sts.evt[E_PCHG]));

    // R10: a rejected insertion only happens while locked
    assert_busy_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> $past(q.sts.lock));
endmodule

// File: tb/tb_slot_hp_ctrl.sv
module tb_slot_hp_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_be = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        evt_button = 1'b0, evt_insert = 1'b0;
    logic        slot_populated = 1'b0, msg_enable = 1'b0;
    logic        irq_level, msg_pulse, detach_req, insert_busy;
    logic [1:0]  attn_ind, pwr_ind;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    slot_hp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_be(cfg_wr_be),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data), .evt_button(evt_button),
        .evt_insert(evt_insert), .slot_populated(slot_populated), .msg_enable(msg_enable),
        .irq_level(irq_level), .msg_pulse(msg_pulse), .detach_req(detach_req),
        .insert_busy(insert_busy), .attn_ind(attn_ind), .pwr_ind(pwr_ind)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] data);
        cfg_wr_en = 1'b1; cfg_wr_be = be; cfg_wr_data = data;
        tick();
        cfg_wr_en = 1'b0; cfg_wr_be = '0; cfg_wr_data = '0;
    endtask

    task automatic do_reset(input logic pop);
        slot_populated = pop;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic press();
        evt_button = 1'b1; tick(); evt_button = 1'b0;
    endtask

    task automatic insert();
        evt_insert = 1'b1; tick(); evt_insert = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2;
        // R1 populated reset: attn 11, pwr ind 01, pwr off 0, pres 1
        do_reset(1'b1);
        check("R1 ctl populated", {16'h0, cfg_rd_data[15:0]}, 32'h0070);
        check("R1 sts populated", {16'h0, cfg_rd_data[31:16]}, 32'h0008);
        check("R1 irq", {31'h0, irq_level}, 32'h0);
        // R1 empty reset: pwr ind 11, pwr off 1
        do_reset(1'b0);
        check("R1 ctl empty", {16'h0, cfg_rd_data[15:0]}, 32'h01F0);
        check("R1 sts empty", {16'h0, cfg_rd_data[31:16]}, 32'h0000);
        check("R1 attn ind", {30'h0, attn_ind}, 32'h3);

        // R2 R3 R4 R9 sweep over all enable patterns and both interrupt modes
        for (int m = 0; m < 2; m++) begin
            msg_enable = m[0];
            for (int en = 0; en < 16; en++) begin
                logic p;
                p = en[3] & en[0];
                wr(4'b0001, 32'h0000_00F0 | en);
                wr(4'b0100, 32'h0007_0000);
                tick();
                check("R5 cleared", {29'h0, cfg_rd_data[18:16]}, 32'h0);
                check("R3 idle level", {31'h0, irq_level}, 32'h0);
                press();
                check("R9 button bit", {31'h0, cfg_rd_data[16]}, 32'h1);
                check("R2 pulse on rise", {31'h0, msg_pulse}, {31'h0, p & m[0]});
                check("R3 level on rise", {31'h0, irq_level}, {31'h0, p & ~m[0]});
                press();
                check("R4 no repeat pulse", {31'h0, msg_pulse}, 32'h0);
                check("R4 level held", {31'h0, irq_level}, {31'h0, p & ~m[0]});
                tick();
                check("R2 pulse one cycle", {31'h0, msg_pulse}, 32'h0);
                wr(4'b0100, 32'h0001_0000);
                check("R2 pulse on fall", {31'h0, msg_pulse}, {31'h0, p & m[0]});
                check("R3 level drops", {31'h0, irq_level}, 32'h0);
            end
        end
        msg_enable = 1'b0;

        // R11: byte 1 only leaves low byte fields alone
        wr(4'b0001, 32'h0000_0030);
        wr(4'b0010, 32'h0000_00CF);
        check("R11 byte0 kept", {24'h0, cfg_rd_data[7:0]}, 32'h30);
        // R5: status bits not cleared without byte 2
        wr(4'b1000, 32'h0007_0000);
        check("R5 no byte2", {29'h0, cfg_rd_data[18:16]}, 32'h4);
        wr(4'b0100, 32'h0007_0000);
        check("R5 byte2 clear", {29'h0, cfg_rd_data[18:16]}, 32'h0);
        // R8: byte 1 write alone completes a command
        wr(4'b0010, 32'h0000_0000);
        check("R8 cmd done", {31'h0, cfg_rd_data[18]}, 32'h1);

        // R6 lock toggle, R10 rejected insertion
        wr(4'b0010, 32'h0000_0200);
        check("R6 reads zero", {31'h0, cfg_rd_data[9]}, 32'h0);
        check("R6 lock set", {31'h0, cfg_rd_data[20]}, 32'h1);
        wr(4'b0100, 32'h0007_0000);
        insert();
        check("R10 busy", {31'h0, insert_busy}, 32'h1);
        check("R10 status kept", {16'h0, cfg_rd_data[31:16]}, 32'h0010);
        tick();
        check("R10 busy one cycle", {31'h0, insert_busy}, 32'h0);
        wr(4'b0010, 32'h0000_0200);
        check("R6 lock cleared", {31'h0, cfg_rd_data[20]}, 32'h0);

        // R9 insertion
        wr(4'b0100, 32'h0007_0000);
        insert();
        check("R9 insert status", {16'h0, cfg_rd_data[31:16]}, 32'h000B);
        check("R10 no busy", {31'h0, insert_busy}, 32'h0);

        // R7 negative: power indicator on, no detach
        wr(4'b0011, 32'h0000_0170);
        check("R7 no detach", {31'h0, detach_req}, 32'h0);
        check("R7 pres kept", {16'h0, cfg_rd_data[31:16]}, 32'h000F);
        // R7 positive
        wr(4'b0011, 32'h0000_01F0);
        check("R7 detach", {31'h0, detach_req}, 32'h1);
        check("R7 status", {16'h0, cfg_rd_data[31:16]}, 32'h0007);
        check("R7 pwr ind", {30'h0, pwr_ind}, 32'h3);
        tick();
        check("R7 detach one cycle", {31'h0, detach_req}, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule